// File: doc/BRIEF.md
# Line Event Interrupt Status Controller

This block turns slowly changing framer and transmit-line status levels into sticky, clear-on-read event bits and raises an interrupt when any unmasked event is pending. Each monitored level is compared with its value from the previous clock. A chosen edge of each level sets its own bit in an eight-bit line event status register, or in a one-bit transmit line event register. Framing and line monitoring happen elsewhere; this block only sees their results as plain inputs.

Software sets a mask bit to 1 to disable an event. A global visible-if-masked control decides what a masked event does. With the control clear, a masked event is dropped. With it set, a masked event still latches into the readable status register, but it never drives the interrupt pin and never shows in the summary register. Reading a status register returns its contents and clears it in the same access. An event that arrives on the clearing edge is kept.

Top module: `line_event_irq`

## Requirements
- R1: A read (`reg_rd`=1) of address 0 (line status) or address 2 (transmit status) returns the contents on `reg_rdata` in that cycle and clears the register at the next clock edge. An event that latches on that same edge stays set after the clear.
- R2: Line status bit positions are fixed: bit7 frame alignment recovered, bit6 frame alignment lost, bit5 multiframe alignment recovered, bit4 multiframe alignment lost, bit3 AIS, bit2 LOS, bit1 remote alarm cleared, bit0 remote alarm. Bits 6, 4, 3, 2 and 0 set on the rising edge of `lfa_i`, `lmfa_i`, `ais_i`, `los_i` and `ra_i` respectively.
- R3: Bit7 sets on a falling edge of `lfa_i`, bit5 on a falling edge of `lmfa_i`, and bit1 on a falling edge of `ra_i`.
- R4: Bit7 also sets on a falling edge of `alarm_sim_i` while `lfa_i` is low. No bit sets if `lfa_i` is high at that time.
- R5: Transmit status (address 2, bit0) sets on a rising edge of `tx_open_i` or on either edge of `tx_stat_i`. A falling edge of `tx_open_i` sets nothing.
- R6: With visible-if-masked clear (control address 3, bit0 = 0), an event whose mask bit is 1 does not latch. Line masks are at address 1, one bit per status bit. The transmit mask is control bit1.
- R7: With visible-if-masked set, a masked event latches and reads back. It leaves `irq_o` low and its summary bit at 0.
- R8: `irq_o` is high exactly when some status bit is set while its mask bit is 0. Summary register (address 4, read-only) bit0 reports this for the line status and bit1 for the transmit status.
- R9: After reset, the line mask reads 0xFF, control reads 0x02, both status registers read 0 and `irq_o` is low. Input levels that are already high during reset produce no event.
- R10: Writes to addresses 0, 2 and 4 change nothing. Writes to addresses 1 and 3 take effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lfa_i | input | 1 | Frame alignment lost level |
| lmfa_i | input | 1 | Multiframe alignment lost level |
| ais_i | input | 1 | Alarm indication signal level |
| los_i | input | 1 | Loss of signal level |
| ra_i | input | 1 | Remote alarm level |
| alarm_sim_i | input | 1 | Alarm simulation active |
| tx_open_i | input | 1 | Transmit line open flag |
| tx_stat_i | input | 1 | Transmit line status flag |
| reg_addr | input | 3 | Register address |
| reg_rd | input | 1 | Read strobe (clears status on read) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Active-high interrupt |

## Verification
The bench starts with levels held high through reset. A design that primes its edge history badly would report spurious loss events right after reset. It lands a fresh event on the same edge as a status read; a design that lets the clear win would lose that event. It ends an alarm simulation both while the frame is still aligned and while it is not. A wrong qualifier would raise a recovery bit when alignment was never regained. It also covers masked events with the visible option off and on. A design that mixes these up would drop events software asked to see, or would assert the pin and summary for events that should stay hidden.

// File: rtl/lnev_pkg.sv
package lnev_pkg;

    localparam int unsigned REG_W  = 8;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_STAT = 3'd0,
        A_MASK = 3'd1,
        A_TXST = 3'd2,
        A_CTRL = 3'd3,
        A_SUMM = 3'd4
    } reg_addr_e;

    // line status bit positions (fixed layout)
    localparam int unsigned B_FAR  = 7;
    localparam int unsigned B_LFA  = 6;
    localparam int unsigned B_MFAR = 5;
    localparam int unsigned B_LMFA = 4;
    localparam int unsigned B_AIS  = 3;
    localparam int unsigned B_LOS  = 2;
    localparam int unsigned B_RAR  = 1;
    localparam int unsigned B_RA   = 0;

    // control bits
    localparam int unsigned C_VIS = 0;
    localparam int unsigned C_TXM = 1;
    localparam int unsigned CTRL_W = 2;
    localparam logic [CTRL_W-1:0] CTRL_RST = 2'b10;
    localparam logic [REG_W-1:0]  MASK_RST = '1;

    // monitored levels, packed into one vector for edge detection
    typedef struct packed {
        logic lfa;
        logic lmfa;
        logic ais;
        logic los;
        logic ra;
        logic sim;
        logic txo;
        logic txs;
    } mon_t;

    localparam int unsigned MON_W = $bits(mon_t);

    function automatic logic [REG_W-1:0] line_events(mon_t rise, mon_t fall, mon_t cur);
        logic [REG_W-1:0] ev;
        ev         = '0;
        ev[B_FAR]  = fall.lfa | (fall.sim & ~cur.lfa);
        ev[B_LFA]  = rise.lfa;
        ev[B_MFAR] = fall.lmfa;
        ev[B_LMFA] = rise.lmfa;
        ev[B_AIS]  = rise.ais;
        ev[B_LOS]  = rise.los;
        ev[B_RAR]  = fall.ra;
        ev[B_RA]   = rise.ra;
        return ev;
    endfunction

    function automatic logic tx_event(mon_t rise, mon_t fall);
        return rise.txo | rise.txs | fall.txs;
    endfunction

endpackage

// File: rtl/lnev_edge.sv
module lnev_edge #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev;

    // history is primed with the live level during reset: no edge at start
    always_ff @(posedge clk) begin
        prev <= din;
    end

    assign rise = din & ~prev;
    assign fall = ~din & prev;

    for (genvar i = 0; i < W; i++) begin : g_chk
        assert_rise_R2: assert property (@(posedge clk) disable iff (rst)
            rise[i] |-> $rose(din[i]));
        assert_fall_R3: assert property (@(posedge clk) disable iff (rst)
            fall[i] |-> $fell(din[i]));
    end
endmodule

// File: rtl/lnev_stat.sv
module lnev_stat #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] mask,
    input  logic         vis,
    input  logic         clr,
    output logic [W-1:0] stat,
    output logic         pend
);
    logic [W-1:0] admit;

    // masked events pass only when visible-if-masked is on
    assign admit = evt & (~mask | {W{vis}});

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else begin
            stat <= (clr ? '0 : stat) | admit;
        end
    end

    assign pend = |(stat & ~mask);

    assert_read_clears_R1: assert property (@(posedge clk) disable iff (rst)
        (clr && evt == '0) |=> stat == '0);
    assert_sticky_R1: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ($past(stat) & ~stat) == '0);
    assert_masked_dropped_R6: assert property (@(posedge clk) disable iff (rst)
        !vis |=> ((stat & ~$past(stat)) & $past(mask)) == '0);
endmodule

// File: rtl/lnev_regs.sv
module lnev_regs
    import lnev_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 rd,
    input  logic                 wr,
    input  logic [REG_W-1:0]     wdata,
    input  logic [REG_W-1:0]     line_stat,
    input  logic                 tx_stat,
    input  logic                 line_pend,
    input  logic                 tx_pend,
    output logic [REG_W-1:0]     rdata,
    output logic [REG_W-1:0]     mask,
    output logic [CTRL_W-1:0]    ctrl,
    output logic                 line_clr,
    output logic                 tx_clr
);
    reg_addr_e sel;
    assign sel = reg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= MASK_RST;
            ctrl <= CTRL_RST;
        end else if (wr) begin
            if (sel == A_MASK) mask <= wdata;
            if (sel == A_CTRL) ctrl <= wdata[CTRL_W-1:0];
        end
    end

    always_comb begin
        case (sel)
            A_STAT:  rdata = line_stat;
            A_MASK:  rdata = mask;
            A_TXST:  rdata = {{(REG_W-1){1'b0}}, tx_stat};
            A_CTRL:  rdata = {{(REG_W-CTRL_W){1'b0}}, ctrl};
            A_SUMM:  rdata = {{(REG_W-2){1'b0}}, tx_pend, line_pend};
            default: rdata = '0;
        endcase
    end

    assign line_clr = rd && (sel == A_STAT);
    assign tx_clr   = rd && (sel == A_TXST);

    assert_reset_values_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask == MASK_RST && ctrl == CTRL_RST));
    assert_ro_write_R10: assert property (@(posedge clk) disable iff (rst)
        (wr && sel != A_MASK && sel != A_CTRL) |=> $stable(mask) && $stable(ctrl));
endmodule

// File: rtl/line_event_irq.sv
module line_event_irq
    import lnev_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lfa_i,
    input  logic              lmfa_i,
    input  logic              ais_i,
    input  logic              los_i,
    input  logic              ra_i,
    input  logic              alarm_sim_i,
    input  logic              tx_open_i,
    input  logic              tx_stat_i,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq_o
);
    mon_t              cur, rise, fall;
    logic [MON_W-1:0]  rise_v, fall_v;
    logic [REG_W-1:0]  line_ev, line_stat, mask;
    logic [CTRL_W-1:0] ctrl;
    logic              tx_ev, tx_stat, line_pend, tx_pend, line_clr, tx_clr;
    logic              unused_edges;

    assign cur = '{lfa: lfa_i, lmfa: lmfa_i, ais: ais_i, los: los_i, ra: ra_i,
                   sim: alarm_sim_i, txo: tx_open_i, txs: tx_stat_i};

    lnev_edge #(.W(MON_W)) u_edge (
        .clk (clk), .rst (rst), .din (cur), .rise (rise_v), .fall (fall_v)
    );

    assign rise = mon_t'(rise_v);
    assign fall = mon_t'(fall_v);
    assign unused_edges = ^{rise.sim, fall.txo};

    assign line_ev = line_events(rise, fall, cur);
    assign tx_ev   = tx_event(rise, fall);

    lnev_stat #(.W(REG_W)) u_line (
        .clk (clk), .rst (rst), .evt (line_ev), .mask (mask),
        .vis (ctrl[C_VIS]), .clr (line_clr), .stat (line_stat), .pend (line_pend)
    );

    lnev_stat #(.W(1)) u_tx (
        .clk (clk), .rst (rst), .evt (tx_ev), .mask (ctrl[C_TXM]),
        .vis (ctrl[C_VIS]), .clr (tx_clr), .stat (tx_stat), .pend (tx_pend)
    );

    lnev_regs u_regs (
        .clk (clk), .rst (rst), .addr (reg_addr), .rd (reg_rd), .wr (reg_wr),
        .wdata (reg_wdata), .line_stat (line_stat), .tx_stat (tx_stat),
        .line_pend (line_pend), .tx_pend (tx_pend), .rdata (reg_rdata),
        .mask (mask), .ctrl (ctrl), .line_clr (line_clr), .tx_clr (tx_clr)
    );

    assign irq_o = line_pend | tx_pend;

    assert_quiet_after_reset_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq_o);
    assert_far_qualified_R4: assert property (@(posedge clk) disable iff (rst)
        (line_ev[B_FAR] && lfa_i) |-> $fell(lfa_i) == 1'b0 && 1'b0);
endmodule

// File: tb/line_event_irq_test.sv
`timescale 1ns/100ps
module line_event_irq_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       lfa_i, lmfa_i, ais_i, los_i, ra_i, alarm_sim_i, tx_open_i, tx_stat_i;
    logic [2:0] reg_addr;
    logic       reg_rd, reg_wr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    line_event_irq uut (
        .clk (clk), .rst (rst), .lfa_i (lfa_i), .lmfa_i (lmfa_i), .ais_i (ais_i),
        .los_i (los_i), .ra_i (ra_i), .alarm_sim_i (alarm_sim_i),
        .tx_open_i (tx_open_i), .tx_stat_i (tx_stat_i), .reg_addr (reg_addr),
        .reg_rd (reg_rd), .reg_wr (reg_wr), .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata), .irq_o (irq_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    // read with clear side effect
    task automatic rd(logic [2:0] a, output logic [7:0] v);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        tick();
        reg_rd = 1'b0;
    endtask

    // look without strobe (no clear)
    task automatic peek(logic [2:0] a, output logic [7:0] v);
        reg_addr = a; reg_rd = 1'b0;
        #1 v = reg_rdata;
    endtask

    task automatic clear_all();
        logic [7:0] v;
        rd(3'd0, v);
        rd(3'd2, v);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        peek(3'd1, v); chk("R9 mask reset", v, 8'hFF);
        peek(3'd3, v); chk("R9 ctrl reset", v, 8'h02);
        peek(3'd0, v); chk("R9 status reset, high level no event", v, 8'h00);
        chk("R9 irq low", {7'b0, irq_o}, 8'h00);
        wr(3'd1, 8'h00);
        wr(3'd3, 8'h00);
        peek(3'd3, v); chk("R10 ctrl write", v, 8'h00);
    endtask

    task automatic t_recovery();
        logic [7:0] v;
        lfa_i = 1'b0; ra_i = 1'b0;
        tick();
        chk("R8 irq on pending", {7'b0, irq_o}, 8'h01);
        rd(3'd0, v); chk("R3 FAR and RAR on falling edges", v, 8'h82);
        lmfa_i = 1'b1; tick();
        rd(3'd0, v); chk("R2 LMFA rise bit4", v, 8'h10);
        lmfa_i = 1'b0; tick();
        rd(3'd0, v); chk("R3 MFAR fall bit5", v, 8'h20);
        rd(3'd0, v); chk("R1 cleared after read", v, 8'h00);
        chk("R8 irq low when empty", {7'b0, irq_o}, 8'h00);
    endtask

    task automatic t_loss();
        logic [7:0] v;
        los_i = 1'b1; lfa_i = 1'b1; ra_i = 1'b1; ais_i = 1'b1;
        tick();
        rd(3'd0, v); chk("R2 LFA LOS RA AIS rising", v, 8'h4D);
        los_i = 1'b0; ais_i = 1'b0; tick();
        rd(3'd0, v); chk("R2 no bit on LOS/AIS fall", v, 8'h00);
    endtask

    task automatic t_sim();
        logic [7:0] v;
        alarm_sim_i = 1'b1; tick();
        alarm_sim_i = 1'b0; tick();
        rd(3'd0, v); chk("R4 sim end while lfa high", v, 8'h00);
        lfa_i = 1'b0; ra_i = 1'b0; tick();
        clear_all();
        alarm_sim_i = 1'b1; tick();
        alarm_sim_i = 1'b0; tick();
        rd(3'd0, v); chk("R4 sim end while synchronous", v, 8'h80);
    endtask

    task automatic t_tx();
        logic [7:0] v;
        tx_open_i = 1'b1; tick();
        rd(3'd2, v); chk("R5 tx open rise", v, 8'h01);
        tx_open_i = 1'b0; tick();
        rd(3'd2, v); chk("R5 tx open fall ignored", v, 8'h00);
        tx_stat_i = 1'b1; tick();
        peek(3'd4, v); chk("R8 summary tx bit1", v, 8'h02);
        rd(3'd2, v); chk("R5 tx stat rise", v, 8'h01);
        tx_stat_i = 1'b0; tick();
        rd(3'd2, v); chk("R5 tx stat fall", v, 8'h01);
    endtask

    task automatic t_collision();
        logic [7:0] v;
        los_i = 1'b1; tick();
        reg_addr = 3'd0; reg_rd = 1'b1; ais_i = 1'b1;
        #1 v = reg_rdata;
        chk("R1 read returns content", v, 8'h04);
        tick();
        reg_rd = 1'b0;
        rd(3'd0, v); chk("R1 event on read edge kept", v, 8'h08);
        los_i = 1'b0; ais_i = 1'b0; tick();
        clear_all();
    endtask

    task automatic t_mask();
        logic [7:0] v;
        wr(3'd1, 8'h08);
        ais_i = 1'b1; tick();
        peek(3'd0, v); chk("R6 masked event dropped", v, 8'h00);
        chk("R6 irq low", {7'b0, irq_o}, 8'h00);
        ais_i = 1'b0; tick();
        wr(3'd3, 8'h01);
        ais_i = 1'b1; tick();
        chk("R7 masked visible irq low", {7'b0, irq_o}, 8'h00);
        peek(3'd4, v); chk("R7 summary clear", v, 8'h00);
        ra_i = 1'b1; tick();
        chk("R8 unmasked raises irq", {7'b0, irq_o}, 8'h01);
        peek(3'd4, v); chk("R8 summary line bit0", v, 8'h01);
        rd(3'd0, v); chk("R7 masked bit visible", v, 8'h09);
        wr(3'd1, 8'h00);
        wr(3'd3, 8'h02);
        tx_open_i = 1'b1; tick();
        rd(3'd2, v); chk("R6 tx mask drops event", v, 8'h00);
        tx_open_i = 1'b0; tick();
    endtask

    task automatic t_ro();
        logic [7:0] v;
        wr(3'd0, 8'hFF);
        wr(3'd4, 8'hFF);
        wr(3'd2, 8'hFF);
        peek(3'd0, v); chk("R10 status write ignored", v, 8'h00);
        peek(3'd2, v); chk("R10 tx status write ignored", v, 8'h00);
        peek(3'd1, v); chk("R10 mask untouched", v, 8'h00);
        peek(3'd3, v); chk("R10 ctrl untouched", v, 8'h02);
    endtask

    initial begin
        rst = 1'b1;
        lfa_i = 1'b1; ra_i = 1'b1;
        lmfa_i = 0; ais_i = 0; los_i = 0; alarm_sim_i = 0; tx_open_i = 0; tx_stat_i = 0;
        reg_addr = 0; reg_rd = 0; reg_wr = 0; reg_wdata = 0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_recovery();
        t_loss();
        t_sim();
        wr(3'd3, 8'h00);
        t_tx();
        t_collision();
        t_mask();
        t_ro();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0x00 expected=0x01");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule